// File: doc/BRIEF.md
# Two-Operand Instruction Operand Fetch Sequencer

This block accepts one 16-bit two-operand instruction word at a time. It decodes the source and destination addressing. It then issues, one by one, the memory reads that the instruction needs on a single shared read port: offset words that follow the instruction, and operand reads. When every access is done, it presents the source value, the destination value and the decoded fields on an output stream. The ALU, result write-back and interrupts belong to other blocks.

Register values come from two combinational read ports that the block addresses straight from the incoming word. The block keeps its own program-counter copy. It starts at the address that follows the instruction word and moves past each extension word consumed. Its final value goes out with the result. A post-increment of a pointer register is not written back. It is reported on the output stream as an enable, a register number and a new value, for the write-back stage to apply.

Both stream edges use valid/ready. An instruction is taken on a cycle where `ins_valid` and `ins_ready` are both high. `ins_ready` is high only while the block is idle. A result is held, unchanged, from the cycle `out_valid` rises until the cycle `out_ready` is seen high. The memory port is a request with back-pressure. While `mem_ready` is low the request and its address hold steady. When both `mem_valid` and `mem_ready` are high, `mem_rdata` must already carry the 16-bit word stored at the even address `mem_addr` with bit 0 cleared. Bytes are stored little-endian, so the odd byte sits in bits 15:8.

Top module: `fmt1_operand_seq`

## Requirements
- R1: After reset, `ins_ready`=1, `out_valid`=0 and `mem_valid`=0. `ins_ready` is high only when neither `mem_valid` nor `out_valid` is high. While `out_valid`=1 and `out_ready`=0, the result stays valid and unchanged.
- R2: Word fields are: opcode = bits 15:12, source register = 11:8, destination mode = bit 7 (1 = indexed), byte flag = bit 6 (1 = byte), source mode = bits 5:4, destination register = 3:0. Opcode, byte flag, destination mode and destination register are passed to the output unchanged.
- R3: With source mode 00 (register) and destination mode 0, no memory access is made, and `out_valid` rises the cycle after acceptance. A register operand's value is the register contents. For register 0 it is the acceptance-time `ins_pc`.
- R4: These sources are constants with no memory access:
  - Register 2 gives 4 for mode 10 and 8 for mode 11.
  - Register 3 gives 0, 1, 2 and 0xFFFF for modes 00, 01, 10 and 11.
- R5: Source mode 10 on any other register makes one read at the register value.
- R6: Source mode 01 reads an offset word at the program counter and advances it by 2. It then reads the operand at offset + register value. With no stalls, each access adds exactly one cycle.
- R7: Indexed addressing on register 2 uses base 0 (absolute). On register 0 it uses the address of the offset word itself (symbolic). This holds for both source and destination.
- R8: Source mode 11 on registers 1 and 4–15 reads at the register value. It reports that register with the value plus 1 (byte) or plus 2 (word) on `out_inc_*`. In every other case `out_inc_en`=0.
- R9: Source mode 11 on register 0 (immediate) takes the word at the program counter and advances the counter by 2. In byte mode it takes that word's low byte. No increment is reported.
- R10: Destination mode 1 reads, after all source accesses, an offset word at the program counter (advanced by 2). It then reads the destination operand at offset + base.
- R11: In byte mode every operand value is one byte, zero-extended. A byte read at an odd address takes bits 15:8 of the returned word, at an even address bits 7:0. Offset words are always whole words.
- R12: When the source post-increments the same register that the destination uses, the destination sees the incremented value, both as a register operand and as an index base.
- R13: A memory request with `mem_ready` low keeps `mem_valid` high and `mem_addr` unchanged into the next cycle. Stalls change no result.
- R14: `out_pc` equals `ins_pc` plus 2 for each extension word consumed: offset words and immediate words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ins_valid | input | 1 | Instruction offered |
| ins_ready | output | 1 | Block idle, will take the instruction |
| ins_word | input | 16 | Instruction word |
| ins_pc | input | 16 | Address following the instruction word |
| reg_a_sel | output | 4 | Source register read select |
| reg_a_data | input | 16 | Source register contents |
| reg_b_sel | output | 4 | Destination register read select |
| reg_b_data | input | 16 | Destination register contents |
| mem_valid | output | 1 | Memory read request |
| mem_ready | input | 1 | Memory accepts request; data valid |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 16 | Aligned word at the read address |
| out_valid | output | 1 | Operands ready |
| out_ready | input | 1 | Consumer takes the result |
| out_src | output | 16 | Source operand value |
| out_dst | output | 16 | Destination operand value |
| out_opcode | output | 4 | Opcode field |
| out_byte | output | 1 | Byte flag |
| out_dmode | output | 1 | Destination mode bit |
| out_dreg | output | 4 | Destination register |
| out_pc | output | 16 | Program counter past extension words |
| out_inc_en | output | 1 | Pointer register post-increment pending |
| out_inc_reg | output | 4 | Register to increment |
| out_inc_val | output | 16 | New value for that register |

## Verification
The hardest case to reach from the ports is a post-incremented source register that is also the indexed destination's base, while the memory port stalls between the two reads. Here the increment must be carried forward across the offset fetch without the port ever showing it. The stimulus sweeps every combination of source register, source mode, destination mode, byte flag and destination register. Odd and even register contents exercise both byte lanes. Every other instruction runs against a memory that refuses every second request, so the forwarded value crosses stall cycles.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  localparam int IW = 16;

  typedef enum logic [2:0] {
    SK_REG,
    SK_CONST,
    SK_INDEX,
    SK_IND,
    SK_AUTO,
    SK_IMM
  } src_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEXT,
    ST_SRD,
    ST_DEXT,
    ST_DRD,
    ST_DONE
  } seq_state_e;

  localparam logic [3:0] REG_PC = 4'd0;
  localparam logic [3:0] REG_SR = 4'd2;
  localparam logic [3:0] REG_CG = 4'd3;
endpackage

// File: rtl/ofs_decode.sv
module ofs_decode
  import ofs_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [IW-1:0]     word,
  output logic [3:0]        opcode,
  output logic [3:0]        sreg,
  output logic              dmode,
  output logic              bw,
  output logic [1:0]        smode,
  output logic [3:0]        dreg,
  output src_kind_e         skind,
  output logic [W-1:0]      cval
);
  assign opcode = word[15:12];
  assign sreg   = word[11:8];
  assign dmode  = word[7];
  assign bw     = word[6];
  assign smode  = word[5:4];
  assign dreg   = word[3:0];

  always_comb begin
    if (sreg == REG_CG || (sreg == REG_SR && smode[1]))
      skind = SK_CONST;
    else begin
      case (smode)
        2'b00:   skind = SK_REG;
        2'b01:   skind = SK_INDEX;
        2'b10:   skind = SK_IND;
        default: skind = (sreg == REG_PC) ? SK_IMM : SK_AUTO;
      endcase
    end
  end

  always_comb begin
    if (sreg == REG_CG) begin
      case (smode)
        2'b00:   cval = '0;
        2'b01:   cval = W'(1);
        2'b10:   cval = W'(2);
        default: cval = '1;
      endcase
    end else begin
      cval = smode[0] ? W'(8) : W'(4);
    end
  end
endmodule

// File: rtl/ofs_lane.sv
module ofs_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0] word,
  input  logic         odd,
  input  logic         byte_mode,
  output logic [W-1:0] val
);
  localparam int H = W / 2;

  always_comb begin
    if (byte_mode)
      val = {{(W-H){1'b0}}, (odd ? word[W-1:H] : word[H-1:0])};
    else
      val = word;
  end
endmodule

// File: rtl/fmt1_operand_seq.sv
module fmt1_operand_seq
  import ofs_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ins_valid,
  output logic          ins_ready,
  input  logic [IW-1:0] ins_word,
  input  logic [W-1:0]  ins_pc,
  output logic [3:0]    reg_a_sel,
  input  logic [W-1:0]  reg_a_data,
  output logic [3:0]    reg_b_sel,
  input  logic [W-1:0]  reg_b_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [W-1:0]  mem_addr,
  input  logic [W-1:0]  mem_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_src,
  output logic [W-1:0]  out_dst,
  output logic [3:0]    out_opcode,
  output logic          out_byte,
  output logic          out_dmode,
  output logic [3:0]    out_dreg,
  output logic [W-1:0]  out_pc,
  output logic          out_inc_en,
  output logic [3:0]    out_inc_reg,
  output logic [W-1:0]  out_inc_val
);
  localparam logic [W-1:0] STEP_W = W'(2);
  localparam logic [W-1:0] STEP_B = W'(1);

  logic [3:0]   d_op, d_sreg, d_dreg;
  logic         d_dmode, d_bw;
  logic [1:0]   d_smode;
  src_kind_e    d_kind;
  logic [W-1:0] d_cval;

  ofs_decode #(.W(W)) u_dec (
    .word(ins_word), .opcode(d_op), .sreg(d_sreg), .dmode(d_dmode),
    .bw(d_bw), .smode(d_smode), .dreg(d_dreg), .skind(d_kind), .cval(d_cval)
  );

  seq_state_e   state;
  src_kind_e    kind_q;
  logic [W-1:0] pc, addr, sval, dval, rb;
  logic [3:0]   op_q, sreg_q, dreg_q;
  logic         bw_q, ad_q, inc_en;
  logic [W-1:0] inc_val;

  logic         accept, mem_fire;
  logic [W-1:0] rega_eff, regb_eff, src_pick;
  logic [W-1:0] src_now, dst_now, mem_val, dst_fwd, inc_next, dbase;

  assign reg_a_sel = d_sreg;
  assign reg_b_sel = d_dreg;
  assign rega_eff  = (d_sreg == REG_PC) ? ins_pc : reg_a_data;
  assign regb_eff  = (d_dreg == REG_PC) ? ins_pc : reg_b_data;
  assign src_pick  = (d_kind == SK_CONST) ? d_cval : rega_eff;

  assign ins_ready = (state == ST_IDLE);
  assign accept    = ins_valid && ins_ready;
  assign mem_valid = (state == ST_SEXT) || (state == ST_SRD) ||
                     (state == ST_DEXT) || (state == ST_DRD);
  assign mem_fire  = mem_valid && mem_ready;
  assign mem_addr  = (state == ST_SEXT || state == ST_DEXT) ? pc : addr;
  assign inc_next  = addr + (bw_q ? STEP_B : STEP_W);

  ofs_lane #(.W(W)) u_src_lane (
    .word(src_pick), .odd(1'b0), .byte_mode(d_bw), .val(src_now));
  ofs_lane #(.W(W)) u_dst_lane (
    .word(regb_eff), .odd(1'b0), .byte_mode(d_bw), .val(dst_now));
  ofs_lane #(.W(W)) u_mem_lane (
    .word(mem_rdata), .odd(mem_addr[0]),
    .byte_mode(bw_q && (state == ST_SRD || state == ST_DRD)), .val(mem_val));
  ofs_lane #(.W(W)) u_fwd_lane (
    .word(inc_next), .odd(1'b0), .byte_mode(bw_q), .val(dst_fwd));

  // Destination index base: absolute, PC-relative, forwarded increment, or register.
  always_comb begin
    if (dreg_q == REG_SR)
      dbase = '0;
    else if (dreg_q == REG_PC)
      dbase = pc;
    else if (inc_en && dreg_q == sreg_q)
      dbase = inc_val;
    else
      dbase = rb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      kind_q  <= SK_REG;
      pc      <= '0;
      addr    <= '0;
      sval    <= '0;
      dval    <= '0;
      rb      <= '0;
      op_q    <= '0;
      sreg_q  <= '0;
      dreg_q  <= '0;
      bw_q    <= 1'b0;
      ad_q    <= 1'b0;
      inc_en  <= 1'b0;
      inc_val <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          op_q   <= d_op;
          sreg_q <= d_sreg;
          dreg_q <= d_dreg;
          bw_q   <= d_bw;
          ad_q   <= d_dmode;
          kind_q <= d_kind;
          pc     <= ins_pc;
          rb     <= regb_eff;
          dval   <= dst_now;
          sval   <= src_now;
          inc_en <= 1'b0;
          case (d_kind)
            SK_REG, SK_CONST: state <= d_dmode ? ST_DEXT : ST_DONE;
            SK_INDEX: begin
              addr  <= (d_sreg == REG_SR) ? '0 : rega_eff;
              state <= ST_SEXT;
            end
            SK_IMM: begin
              addr  <= ins_pc;
              state <= ST_SRD;
            end
            default: begin
              addr  <= rega_eff;
              state <= ST_SRD;
            end
          endcase
        end
        ST_SEXT: if (mem_fire) begin
          addr  <= addr + mem_rdata;
          pc    <= pc + STEP_W;
          state <= ST_SRD;
        end
        ST_SRD: if (mem_fire) begin
          sval <= mem_val;
          if (kind_q == SK_IMM)
            pc <= pc + STEP_W;
          if (kind_q == SK_AUTO) begin
            inc_en  <= 1'b1;
            inc_val <= inc_next;
            if (dreg_q == sreg_q && !ad_q)
              dval <= dst_fwd;
          end
          state <= ad_q ? ST_DEXT : ST_DONE;
        end
        ST_DEXT: if (mem_fire) begin
          addr  <= dbase + mem_rdata;
          pc    <= pc + STEP_W;
          state <= ST_DRD;
        end
        ST_DRD: if (mem_fire) begin
          dval  <= mem_val;
          state <= ST_DONE;
        end
        ST_DONE: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign out_valid   = (state == ST_DONE);
  assign out_src     = sval;
  assign out_dst     = dval;
  assign out_opcode  = op_q;
  assign out_byte    = bw_q;
  assign out_dmode   = ad_q;
  assign out_dreg    = dreg_q;
  assign out_pc      = pc;
  assign out_inc_en  = inc_en;
  assign out_inc_reg = sreg_q;
  assign out_inc_val = inc_val;

  // R13: a stalled request holds its address
  p_mem_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr));

  // R1: result held under output back-pressure
  p_out_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_src) &&
                                $stable(out_dst) && $stable(out_pc));

  // R1: idle side never overlaps a request or a result
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ready |-> !mem_valid && !out_valid);

  // R3: register to register completes the next cycle
  p_reg_fast_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && d_kind == SK_REG && !d_dmode |=> out_valid);

  // R4: constant source with register destination needs no memory
  p_const_nomem_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && d_kind == SK_CONST && !d_dmode |=> out_valid && !mem_valid);

  // R8: only a post-increment source reports an increment
  p_inc_auto_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_inc_en |-> kind_q == SK_AUTO);
endmodule

// File: tb/tb_fmt1_operand_seq.sv
`timescale 1ns/1ps
module tb_fmt1_operand_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [15:0] ins_word = '0;
  logic [15:0] ins_pc = '0;
  logic [3:0]  reg_a_sel, reg_b_sel;
  logic [15:0] reg_a_data, reg_b_data;
  logic        mem_valid, mem_ready;
  logic [15:0] mem_addr, mem_rdata;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_src, out_dst, out_pc, out_inc_val;
  logic [3:0]  out_opcode, out_dreg, out_inc_reg;
  logic        out_byte, out_dmode, out_inc_en;
  logic        stall_en = 1'b0;
  logic        tick = 1'b0;

  int vectors = 0;
  int fails = 0;

  always #2 clk = ~clk;

  function automatic logic [15:0] rv(input logic [3:0] i);
    return 16'h2000 + 16'(i) * 16'h0123;
  endfunction

  function automatic logic [15:0] mf(input logic [15:0] a);
    logic [15:0] al;
    al = {a[15:1], 1'b0};
    return (al * 16'h9E37) ^ 16'h5A5A;
  endfunction

  function automatic logic [15:0] rd(input logic [15:0] a, input logic b);
    logic [15:0] w;
    w = mf(a);
    if (!b) return w;
    return a[0] ? {8'h00, w[15:8]} : {8'h00, w[7:0]};
  endfunction

  always_ff @(posedge clk) tick <= ~tick;
  assign mem_ready  = !(stall_en && tick);
  assign reg_a_data = rv(reg_a_sel);
  assign reg_b_data = rv(reg_b_sel);
  assign mem_rdata  = mf(mem_addr);

  fmt1_operand_seq dut (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_word(ins_word), .ins_pc(ins_pc),
    .reg_a_sel(reg_a_sel), .reg_a_data(reg_a_data),
    .reg_b_sel(reg_b_sel), .reg_b_data(reg_b_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_src(out_src), .out_dst(out_dst), .out_opcode(out_opcode), .out_byte(out_byte),
    .out_dmode(out_dmode), .out_dreg(out_dreg), .out_pc(out_pc),
    .out_inc_en(out_inc_en), .out_inc_reg(out_inc_reg), .out_inc_val(out_inc_val)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic run_one(input int idx, input logic [3:0] s, input logic [1:0] sm,
                         input logic ad, input logic bw, input logic [3:0] d);
    logic [15:0] pc0, pc, src, dst, ext, a, rb, incv;
    logic        inc;
    int          n, cyc, acc;
    logic [3:0]  op;
    string       stag, dtag;
    bit          hold;
    op   = 4'(4 + idx % 12);
    pc0  = 16'h4000 + {idx[14:0], 1'b0};
    pc   = pc0;
    n    = 0;
    inc  = 1'b0;
    incv = '0;
    hold = (idx % 5 == 0);
    // source model
    if (s == 4'd3) begin
      src = (sm == 2'd3) ? 16'hFFFF : 16'(sm);
      stag = "R4";
    end else if (s == 4'd2 && sm[1]) begin
      src = sm[0] ? 16'd8 : 16'd4;
      stag = "R4";
    end else if (sm == 2'd0) begin
      src = (s == 4'd0) ? pc0 : rv(s);
      stag = "R3";
    end else if (sm == 2'd1) begin
      ext = mf(pc);
      a = ext + ((s == 4'd2) ? 16'h0 : (s == 4'd0) ? pc : rv(s));
      pc = pc + 2;
      src = rd(a, bw);
      n += 2;
      stag = (s == 4'd0 || s == 4'd2) ? "R7" : "R6";
    end else if (sm == 2'd2) begin
      a = (s == 4'd0) ? pc : rv(s);
      src = rd(a, bw);
      n += 1;
      stag = "R5";
    end else if (s == 4'd0) begin
      src = mf(pc);
      pc = pc + 2;
      n += 1;
      stag = "R9";
    end else begin
      a = rv(s);
      src = rd(a, bw);
      inc = 1'b1;
      incv = a + (bw ? 16'd1 : 16'd2);
      n += 1;
      stag = "R8";
    end
    if (bw) src = {8'h00, src[7:0]};
    // destination model
    rb = (d == 4'd0) ? pc0 : rv(d);
    if (inc && d == s) rb = incv;
    if (!ad) begin
      dst = bw ? {8'h00, rb[7:0]} : rb;
      dtag = (inc && d == s) ? "R12" : "R3";
    end else begin
      ext = mf(pc);
      a = ext + ((d == 4'd2) ? 16'h0 : (d == 4'd0) ? pc : rb);
      pc = pc + 2;
      dst = rd(a, bw);
      n += 2;
      dtag = (d == 4'd0 || d == 4'd2) ? "R7" : (inc && d == s) ? "R12" : "R10";
    end
    if (bw) begin
      stag = {stag, "+R11"};
      dtag = {dtag, "+R11"};
    end
    // drive
    stall_en  = idx[0];
    ins_word  = {op, s, ad, bw, sm, d};
    ins_pc    = pc0;
    ins_valid = 1'b1;
    @(negedge clk);
    ins_valid = 1'b0;
    cyc = 0;
    acc = 0;
    while (!out_valid && cyc < 1000) begin
      if (mem_valid && mem_ready) acc++;
      cyc++;
      @(negedge clk);
    end
    check(stag, 32'(out_src), 32'(src));
    check(dtag, 32'(out_dst), 32'(dst));
    check("R14", 32'(out_pc), 32'(pc));
    check("R2", {24'h0, out_opcode, out_byte, out_dmode, 2'b0}, {24'h0, op, bw, ad, 2'b0});
    check("R2", 32'(out_dreg), 32'(d));
    check("R8", 32'(out_inc_en), 32'(inc));
    if (inc) check("R8", {12'h0, out_inc_reg, out_inc_val}, {12'h0, s, incv});
    check(stall_en ? "R13" : "R6", 32'(acc), 32'(n));
    if (!stall_en) check("R3", 32'(cyc), 32'(n));
    if (hold) begin
      @(negedge clk);
      check("R1", {15'h0, out_valid, out_src}, {15'h0, 1'b1, src});
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int idx;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", {29'h0, ins_ready, out_valid, mem_valid}, {29'h0, 3'b100});
    idx = 0;
    for (int s = 0; s < 16; s++)
      for (int sm = 0; sm < 4; sm++)
        for (int ad = 0; ad < 2; ad++)
          for (int bw = 0; bw < 2; bw++)
            for (int d = 0; d < 16; d++) begin
              run_one(idx, 4'(s), 2'(sm), 1'(ad), 1'(bw), 4'(d));
              idx++;
            end
    finish_run();
  end
endmodule